// File: doc/BRIEF.md
# Cascadable Dual 8-bit Compare Timer

This block holds two 8-bit up-counters, a lower timer and an upper timer. Each has its own compare register and its own match interrupt. A counter advances by one on each accepted count pulse. An accepted pulse is a cycle in which that timer's tick input and count enable are both high and no read strobe is present. When the new count equals the compare value, the timer raises a one-cycle interrupt pulse. In clear-and-start mode, a counter that already sits on its compare value returns to 00h on the next accepted pulse instead of advancing. A prescaler upstream supplies the tick pulses. An interrupt controller downstream receives the pulses and applies any masking.

When cascade is set, the pair acts as one 16-bit timer. The lower counter holds the low byte and the upper counter holds the high byte. The upper counter advances only when the lower one wraps from FFh to 00h. The two compare registers form one 16-bit compare value, and a 16-bit match raises the lower interrupt. A host that reads the count asserts the read strobe. Any tick that arrives in the same cycle is dropped, so the value read stays stable.

All pins are plain control and status signals. The block carries no data stream, so it has no valid/ready handshake and applies no back-pressure.

Top module: `tpair_timer`

## Requirements
- R1: An accepted pulse (tick[k] high, run_en[k] high, rd_stb low) raises counter k by one, visible the next cycle. FFh wraps to 00h.
- R2: Reset sets both counters, both compare registers and both interrupt outputs to 0. A low run_en[k] makes counter k read 00h on the next cycle.
- R3: cmp_we[0] loads cmp_wdata[7:0] into the lower compare register, and cmp_we[1] loads cmp_wdata[15:8] into the upper one. Any value 00h–FFh may be written at any time, including while counting.
- R4: irq[k] is high for one cycle, in the same cycle the count becomes equal to the compare value through an accepted pulse. Equality created by a compare write raises no interrupt.
- R5: With clr_mode[k] = 1 (clear-and-start), an accepted pulse that finds counter k equal to its compare value sets the counter to 00h.
- R6: With cascade = 1, the upper counter advances only on the accepted lower pulse at which the lower counter wraps from FFh to 00h. tick[1] is ignored.
- R7: With cascade = 1, irq[0] fires when the 16-bit count {cnt_hi, cnt_lo} becomes equal to the 16-bit compare value. irq[1] still fires on an upper-byte match at an upper increment.
- R8: With cascade = 1, a low run_en[0] zeroes both counters. Clear-and-start, selected by clr_mode[0], acts on the 16-bit match and zeroes both counters.
- R9: A tick in a cycle with rd_stb high is dropped, and the counters keep their values.
- R10: With cascade = 0, each timer counts only its own tick, and the two timers do not affect each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 2 | Count pulse per timer (bit 0 lower, bit 1 upper) |
| run_en | input | 2 | Count enable per timer; low clears that counter |
| clr_mode | input | 2 | 1 selects clear-and-start mode per timer |
| cascade | input | 1 | 1 joins the pair into one 16-bit timer |
| cmp_we | input | 2 | Compare-register write enables, one per byte lane |
| cmp_wdata | input | 16 | Compare write data; [7:0] lower, [15:8] upper |
| rd_stb | input | 1 | Read strobe; holds off counting this cycle |
| cnt_lo | output | 8 | Lower counter value |
| cnt_hi | output | 8 | Upper counter value |
| irq | output | 2 | One-cycle match pulses (bit 0 lower, bit 1 upper) |

## Verification
Every result is a register output, so counts, clears and interrupt pulses all become visible exactly one cycle after the edge that samples the stimulus. The interrupt appears in the same cycle as the matching count. The bench drives inputs 1 ns after a rising edge and checks outputs 1 ns after the following edge. An interrupt is therefore checked on the same cycle as the count it belongs to. The cycle after that is checked to confirm that the pulse has ended. Wrap and cascade carries are reached by counting the exact number of ticks, so the carry lands on a known cycle.

// File: rtl/tpair_pkg.sv
package tpair_pkg;
  localparam int unsigned N_TMR = 2;
  typedef enum logic {
    MODE_FREE  = 1'b0,
    MODE_CLEAR = 1'b1
  } tmr_mode_e;
endpackage

// File: rtl/tpair_cmp_reg.sv
module tpair_cmp_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cmp_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  cmp_q <= '0;
    else if (we) cmp_q <= wdata;
  end
endmodule

// File: rtl/tpair_cnt_cell.sv
module tpair_cnt_cell #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         step,
  input  logic         zero,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_nxt
);
  always_comb begin
    if (!run || zero) cnt_nxt = '0;
    else if (step)    cnt_nxt = cnt_q + 1'b1;
    else              cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/tpair_timer.sv
module tpair_timer #(
  parameter int unsigned W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     tick,
  input  logic [1:0]     run_en,
  input  logic [1:0]     clr_mode,
  input  logic           cascade,
  input  logic [1:0]     cmp_we,
  input  logic [2*W-1:0] cmp_wdata,
  input  logic           rd_stb,
  output logic [W-1:0]   cnt_lo,
  output logic [W-1:0]   cnt_hi,
  output logic [1:0]     irq
);
  import tpair_pkg::*;

  localparam int unsigned NT   = N_TMR;
  localparam logic [W-1:0] CMAX = '1;

  logic [W-1:0]  cnt_q   [NT];
  logic [W-1:0]  cnt_nxt [NT];
  logic [W-1:0]  cmp_q   [NT];
  logic [NT-1:0] run, step, zero;
  logic [NT-1:0] irq_d, irq_q;
  logic          eq_lo, eq_hi, eq16, clr_lo, clr_hi, match_lo, wrap_lo;

  generate
    for (genvar k = 0; k < NT; k++) begin : g_tmr
      tpair_cmp_reg #(.W(W)) u_cmp (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cmp_we[k]),
        .wdata (cmp_wdata[k*W +: W]),
        .cmp_q (cmp_q[k])
      );
      tpair_cnt_cell #(.W(W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run[k]),
        .step    (step[k]),
        .zero    (zero[k]),
        .cnt_q   (cnt_q[k]),
        .cnt_nxt (cnt_nxt[k])
      );
    end
  endgenerate

  always_comb begin
    eq_lo  = (cnt_q[0] == cmp_q[0]);
    eq_hi  = (cnt_q[1] == cmp_q[1]);
    eq16   = eq_lo && eq_hi;
    clr_lo = (tmr_mode_e'(clr_mode[0]) == MODE_CLEAR);
    clr_hi = (tmr_mode_e'(clr_mode[1]) == MODE_CLEAR);

    // lower enable also gates the upper counter when joined
    run[0] = run_en[0];
    run[1] = run_en[1] && (!cascade || run_en[0]);

    step[0]  = tick[0] && run_en[0] && !rd_stb;
    match_lo = cascade ? eq16 : eq_lo;
    zero[0]  = step[0] && clr_lo && match_lo;
    wrap_lo  = step[0] && !zero[0] && (cnt_q[0] == CMAX);

    step[1] = cascade ? (wrap_lo && run_en[1])
                      : (tick[1] && run_en[1] && !rd_stb);
    zero[1] = cascade ? zero[0] : (step[1] && clr_hi && eq_hi);

    irq_d[0] = step[0] && (cascade ? ({cnt_nxt[1], cnt_nxt[0]} == {cmp_q[1], cmp_q[0]})
                                   : (cnt_nxt[0] == cmp_q[0]));
    irq_d[1] = step[1] && (cnt_nxt[1] == cmp_q[1]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= irq_d;
  end

  assign cnt_lo = cnt_q[0];
  assign cnt_hi = cnt_q[1];
  assign irq    = irq_q;
endmodule

// File: rtl/tpair_timer_chk.sv
module tpair_timer_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   tick,
  input logic [1:0]   run_en,
  input logic         clr_lo_mode,
  input logic         cascade,
  input logic         rd_stb,
  input logic [W-1:0] cnt_lo,
  input logic [W-1:0] cnt_hi,
  input logic         irq_lo
);
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en[0] && tick[0] && !rd_stb && !clr_lo_mode) |=> cnt_lo == W'($past(cnt_lo) + 1'b1)); // R1

  AST_DISABLE_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en[0] |=> cnt_lo == '0); // R2

  AST_IRQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lo |-> $past(tick[0] && run_en[0] && !rd_stb)); // R4

  AST_CASC_HOLD_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (cascade && run_en == 2'b11 && !clr_lo_mode && cnt_lo != '1) |=> $stable(cnt_hi)); // R6

  AST_CASC_CLEAR_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (cascade && !run_en[0]) |=> cnt_hi == '0); // R8

  AST_READ_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && run_en == 2'b11) |=> ($stable(cnt_lo) && $stable(cnt_hi))); // R9
endmodule

bind tpair_timer tpair_timer_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick        (tick),
  .run_en      (run_en),
  .clr_lo_mode (clr_mode[0]),
  .cascade     (cascade),
  .rd_stb      (rd_stb),
  .cnt_lo      (cnt_lo),
  .cnt_hi      (cnt_hi),
  .irq_lo      (irq[0])
);

// File: tb/tpair_timer_tb.sv
`timescale 1ns/1ps
module tpair_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  tick, run_en, clr_mode, cmp_we, irq;
  logic        cascade, rd_stb;
  logic [15:0] cmp_wdata;
  logic [7:0]  cnt_lo, cnt_hi;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  tpair_timer #(.W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run_en(run_en), .clr_mode(clr_mode),
    .cascade(cascade), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata), .rd_stb(rd_stb),
    .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .irq(irq)
  );

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
    tick = '0; rd_stb = 1'b0; cmp_we = '0;
  endtask

  task automatic tk(input logic [1:0] t, input int n);
    for (int i = 0; i < n; i++) begin tick = t; cyc(); end
  endtask

  task automatic wr(input logic [1:0] we, input logic [15:0] d);
    cmp_we = we; cmp_wdata = d; cyc();
  endtask

  task automatic zero_all();
    run_en = 2'b00; cyc(); run_en = 2'b11;
  endtask

  task automatic t_reset();
    check("R2", "lo after reset", {8'h0, cnt_lo}, 16'h0);
    check("R2", "hi after reset", {8'h0, cnt_hi}, 16'h0);
    check("R2", "irq after reset", {14'h0, irq}, 16'h0);
  endtask

  task automatic t_count_wrap();
    tk(2'b01, 3);
    check("R1", "lo after 3", {8'h0, cnt_lo}, 16'h3);
    check("R10", "hi untouched", {8'h0, cnt_hi}, 16'h0);
    tk(2'b10, 2);
    check("R10", "hi own ticks", {8'h0, cnt_hi}, 16'h2);
    check("R10", "lo untouched", {8'h0, cnt_lo}, 16'h3);
    tk(2'b01, 252);
    check("R1", "lo at FF", {8'h0, cnt_lo}, 16'hFF);
    check("R4", "no irq before match", {14'h0, irq}, 16'h0);
    tk(2'b01, 1);
    check("R1", "lo wraps", {8'h0, cnt_lo}, 16'h0);
    check("R2", "reset cmp 00 match", {14'h0, irq}, 16'h1);
    cyc();
    check("R4", "pulse ends", {14'h0, irq}, 16'h0);
  endtask

  task automatic t_match();
    zero_all();
    check("R2", "disable zeroes lo", {8'h0, cnt_lo}, 16'h0);
    check("R2", "disable zeroes hi", {8'h0, cnt_hi}, 16'h0);
    wr(2'b01, 16'h0004);
    tk(2'b01, 3);
    check("R4", "no irq at 3", {14'h0, irq}, 16'h0);
    tk(2'b01, 1);
    check("R4", "irq at match", {14'h0, irq}, 16'h1);
    check("R3", "lo at cmp", {8'h0, cnt_lo}, 16'h4);
    cyc();
    check("R4", "one-cycle pulse", {14'h0, irq}, 16'h0);
    wr(2'b01, 16'h0006);
    wr(2'b01, 16'h0004);
    check("R4", "write equality no irq", {14'h0, irq}, 16'h0);
    wr(2'b10, 16'h0201);
    tk(2'b10, 2);
    check("R3", "upper lane match", {14'h0, irq}, 16'h2);
    check("R3", "lo kept", {8'h0, cnt_lo}, 16'h4);
  endtask

  task automatic t_clear_start();
    zero_all();
    clr_mode = 2'b01;
    wr(2'b01, 16'h0002);
    tk(2'b01, 2);
    check("R5", "reach cmp", {8'h0, cnt_lo}, 16'h2);
    check("R5", "irq at cmp", {14'h0, irq}, 16'h1);
    tk(2'b01, 1);
    check("R5", "cleared", {8'h0, cnt_lo}, 16'h0);
    check("R5", "no irq on clear", {14'h0, irq}, 16'h0);
    tk(2'b01, 1);
    check("R5", "restarted", {8'h0, cnt_lo}, 16'h1);
    clr_mode = 2'b00;
  endtask

  task automatic t_read();
    rd_stb = 1'b1; tick = 2'b11; cyc();
    check("R9", "lo held on read", {8'h0, cnt_lo}, 16'h1);
    check("R9", "hi held on read", {8'h0, cnt_hi}, 16'h0);
    tk(2'b01, 1);
    check("R9", "tick dropped not deferred", {8'h0, cnt_lo}, 16'h2);
  endtask

  task automatic t_disable();
    tk(2'b10, 3);
    run_en = 2'b10; cyc(); run_en = 2'b11;
    check("R2", "lo cleared", {8'h0, cnt_lo}, 16'h0);
    check("R10", "hi kept", {8'h0, cnt_hi}, 16'h3);
  endtask

  task automatic t_cascade();
    zero_all();
    cascade = 1'b1;
    wr(2'b11, 16'h0103);
    tk(2'b10, 1);
    check("R6", "hi ignores own tick", {8'h0, cnt_hi}, 16'h0);
    tk(2'b01, 255);
    check("R6", "no carry before wrap", {cnt_hi, cnt_lo}, 16'h00FF);
    tk(2'b01, 1);
    check("R6", "carry on wrap", {cnt_hi, cnt_lo}, 16'h0100);
    check("R7", "upper byte irq only", {14'h0, irq}, 16'h2);
    tk(2'b01, 3);
    check("R7", "16-bit count", {cnt_hi, cnt_lo}, 16'h0103);
    check("R7", "16-bit match irq", {14'h0, irq}, 16'h1);
    run_en = 2'b10; cyc(); run_en = 2'b11;
    check("R8", "lower disable zeroes pair", {cnt_hi, cnt_lo}, 16'h0000);
    clr_mode = 2'b01;
    wr(2'b11, 16'h0101);
    tk(2'b01, 257);
    check("R8", "at 16-bit cmp", {cnt_hi, cnt_lo}, 16'h0101);
    check("R7", "irq at 0101", {14'h0, irq}, 16'h1);
    tk(2'b01, 1);
    check("R8", "clear-and-start zeroes pair", {cnt_hi, cnt_lo}, 16'h0000);
    clr_mode = 2'b00; cascade = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; tick = '0; run_en = 2'b11; clr_mode = '0; cascade = 1'b0;
    cmp_we = '0; cmp_wdata = '0; rd_stb = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_count_wrap();
    t_match();
    t_clear_start();
    t_read();
    t_disable();
    t_cascade();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule